// File: doc/BRIEF.md
# Block Cipher Mode Control Register

This block is the control and status register of a 128-bit block cipher engine. A host programs the cipher mode, the counter width for counter mode and the direction through one control word on a simple single-cycle register bus. It then writes the two halves of the message length. Writing both length words after the last change of configuration completes a context. At that point the block checks that the selected mode combination is legal. It then either fires a one-cycle start pulse to the engine or records a sticky configuration error.

After a legal start, two handshake flags pace 16-byte blocks between host and engine. The input flag means the input buffer is free. The host clears it by writing 0 once it has loaded a block, and the engine's block-done event sets it again. The output flag means a result block is waiting. The engine sets it and the host clears it by writing 0. Written 1s never touch either flag. In DMA operation the flags are cleared by pulses from the DMA side, and host writes to them are ignored.

Top module: `cmc_ctrl`

## Requirements
- R1: After reset the control word (offset 0x0) reads 0x00000008: the key-size field (bits 4:3) reads 01, every other bit reads 0. Both length words read 0, eng_start is 0, cfg_err is 0, eng_in_valid is 0 and eng_out_free is 1.
- R2: Control word layout: CCM enable bit 18, CBC-MAC enable bit 15, counter width bits 8:7, CTR enable bit 6, CBC enable bit 5, key size bits 4:3, encrypt bit 2, input-ready bit 1, output-ready bit 0. Every other bit reads 0 and ignores writes. The key-size field always reads 01, whatever is written to it.
- R3: The stored configuration drives eng_ccm, eng_mac, eng_ctr, eng_cbc, eng_encrypt (1 = encrypt, 0 = decrypt) and eng_ctr_width. The width code 0/1/2/3 selects 32/64/96/128 counter bits. eng_len is {upper word, lower word}.
- R4: A context completes on the write that leaves both length words written (lower at 0x4, upper at 0x8, in either order) since the last configuration change. A control write that changes any of bits 18, 15, 8:7, 6, 5 or 2 discards length writes made before it. A control write that changes none of them does not.
- R5: On a legal completion, eng_start is high for exactly the one cycle after the completing write, input-ready becomes 1 and the context becomes active.
- R6: A completion is illegal when CCM is set without CTR, when CCM is combined with CBC or CBC-MAC, or when CBC-MAC is set with encrypt = 0. An illegal completion gives no start pulse, sets cfg_err until reset and leaves the flags unchanged.
- R7: With dma_sel = 0, a control write with bit 1 = 0 clears input-ready, and a write with bit 1 = 1 leaves it unchanged.
- R8: eng_out_valid sets output-ready, and eng_out_free is its inverse. With dma_sel = 0, a control write with bit 0 = 0 clears output-ready, and bit 0 = 1 leaves it unchanged.
- R9: eng_block_done sets input-ready while a context is active. A set event and a clear in the same cycle leave the flag at 1.
- R10: With dma_sel = 1, host writes leave both flags unchanged, dma_in_take clears input-ready and dma_out_take clears output-ready. With dma_sel = 0 the two DMA pulses have no effect.
- R11: eng_in_valid is 1 exactly while a context is active and input-ready is 0. A configuration change ends the active context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| dma_sel | input | 1 | Flags are paced by DMA pulses instead of host writes |
| dma_in_take | input | 1 | DMA has loaded an input block (clears input-ready) |
| dma_out_take | input | 1 | DMA has fetched an output block (clears output-ready) |
| eng_block_done | input | 1 | Engine consumed the input block |
| eng_out_valid | input | 1 | Engine has a result block |
| eng_start | output | 1 | One-cycle start pulse for a legal context |
| eng_in_valid | output | 1 | Input block is loaded and may be used |
| eng_out_free | output | 1 | Output buffer is free for the next block |
| eng_ccm | output | 1 | CCM selected |
| eng_mac | output | 1 | CBC-MAC selected |
| eng_ctr | output | 1 | CTR selected |
| eng_cbc | output | 1 | CBC selected |
| eng_encrypt | output | 1 | 1 encrypt, 0 decrypt |
| eng_ctr_width | output | 2 | Counter width code |
| eng_len | output | 2*DATA_W | Message length {upper, lower} |
| cfg_err | output | 1 | Sticky illegal-mode flag |

## Verification
The hardest cases to reach are the length words that go stale. One case is a length write made before a configuration change, which must not count toward the next context. The other is a control write that only clears a flag, which must not discard a pending length write. The stimulus sets up both cases: it writes the lower length, then changes the counter width, and checks that the upper write alone starts nothing. It then repeats the lower write with a flag-only control write in between. A scoreboard holds the expected mode and length for each start, so a missing pulse, an extra pulse or a wrong configuration each show up as a mismatch.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

   localparam int unsigned BIT_CCM  = 18;
   localparam int unsigned BIT_MAC  = 15;
   localparam int unsigned BIT_CW   = 7;
   localparam int unsigned BIT_CTR  = 6;
   localparam int unsigned BIT_CBC  = 5;
   localparam int unsigned BIT_KEY  = 3;
   localparam int unsigned BIT_ENC  = 2;
   localparam int unsigned BIT_IRDY = 1;
   localparam int unsigned BIT_ORDY = 0;
   localparam int unsigned CTRL_MSB = BIT_CCM;
   localparam int unsigned NUM_FLAGS = 2;

   localparam logic [1:0] KEY_128 = 2'b01;

   typedef enum logic [1:0] {
      CW_32  = 2'd0,
      CW_64  = 2'd1,
      CW_96  = 2'd2,
      CW_128 = 2'd3
   } ctr_width_e;

   typedef struct packed {
      logic       ccm;
      logic       mac;
      logic       ctr;
      logic       cbc;
      logic       enc;
      ctr_width_e cw;
   } mode_cfg_t;

   function automatic mode_cfg_t cfg_from_word(input logic [CTRL_MSB:0] w);
      mode_cfg_t c;
      c.ccm = w[BIT_CCM];
      c.mac = w[BIT_MAC];
      c.ctr = w[BIT_CTR];
      c.cbc = w[BIT_CBC];
      c.enc = w[BIT_ENC];
      c.cw  = ctr_width_e'(w[BIT_CW+1:BIT_CW]);
      return c;
   endfunction

   function automatic logic [CTRL_MSB:0] cfg_to_word(input mode_cfg_t c);
      logic [CTRL_MSB:0] w;
      w = '0;
      w[BIT_CCM] = c.ccm;
      w[BIT_MAC] = c.mac;
      w[BIT_CTR] = c.ctr;
      w[BIT_CBC] = c.cbc;
      w[BIT_ENC] = c.enc;
      w[BIT_CW+1:BIT_CW] = c.cw;
      return w;
   endfunction

endpackage

// File: rtl/cmc_legal.sv
module cmc_legal
   import cmc_pkg::*;
#(
   parameter bit MAC_ENC_ONLY = 1'b1
) (
   input  mode_cfg_t cfg,
   output logic      illegal
);

   logic ccm_bad;
   logic mac_bad;

   // CCM needs CTR and excludes the chaining modes
   assign ccm_bad = cfg.ccm & (~cfg.ctr | cfg.cbc | cfg.mac);

   generate
      if (MAC_ENC_ONLY) begin : g_mac_dir
         assign mac_bad = cfg.mac & ~cfg.enc;
      end else begin : g_mac_any
         assign mac_bad = 1'b0;
      end
   endgenerate

   assign illegal = ccm_bad | mac_bad;

endmodule

// File: rtl/cmc_flag.sv
module cmc_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic host_wr,
   input  logic host_bit,
   input  logic dma_sel,
   input  logic dma_clr,
   input  logic set_evt,
   output logic q
);

   logic clr;

   assign clr = dma_sel ? dma_clr : (host_wr & ~host_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (set_evt) begin
         q <= 1'b1;
      end else if (clr) begin
         q <= 1'b0;
      end
   end

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> q);

   // R7
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_evt) |=> !q);

   // R10
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !set_evt) |=> $stable(q));

endmodule

// File: rtl/cmc_ctx.sv
module cmc_ctx (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_change,
   input  logic wr_lo,
   input  logic wr_hi,
   input  logic illegal,
   output logic ctx_ok,
   output logic start,
   output logic active,
   output logic err
);

   logic lo_seen;
   logic hi_seen;
   logic done;
   logic ctx_bad;

   assign done    = (wr_lo | wr_hi) & (lo_seen | wr_lo) & (hi_seen | wr_hi);
   assign ctx_ok  = done & ~illegal;
   assign ctx_bad = done & illegal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_seen <= 1'b0;
         hi_seen <= 1'b0;
         start   <= 1'b0;
         active  <= 1'b0;
         err     <= 1'b0;
      end else begin
         start <= ctx_ok;
         if (cfg_change || done) begin
            lo_seen <= 1'b0;
            hi_seen <= 1'b0;
         end else begin
            if (wr_lo) lo_seen <= 1'b1;
            if (wr_hi) hi_seen <= 1'b1;
         end
         if (cfg_change || ctx_bad) begin
            active <= 1'b0;
         end else if (ctx_ok) begin
            active <= 1'b1;
         end
         if (ctx_bad) begin
            err <= 1'b1;
         end
      end
   end

   // R5
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R6
   bad_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && illegal) |=> (!start && err));

   // R11
   cfg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_change |=> !active);

endmodule

// File: rtl/cmc_ctrl.sv
module cmc_ctrl
   import cmc_pkg::*;
#(
   parameter int unsigned      DATA_W       = 32,
   parameter int unsigned      ADDR_W       = 4,
   parameter logic [ADDR_W-1:0] CTRL_OFS    = 'h0,
   parameter logic [ADDR_W-1:0] LEN_LO_OFS  = 'h4,
   parameter logic [ADDR_W-1:0] LEN_HI_OFS  = 'h8,
   parameter bit                MAC_ENC_ONLY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                dma_sel,
   input  logic                dma_in_take,
   input  logic                dma_out_take,
   input  logic                eng_block_done,
   input  logic                eng_out_valid,
   output logic                eng_start,
   output logic                eng_in_valid,
   output logic                eng_out_free,
   output logic                eng_ccm,
   output logic                eng_mac,
   output logic                eng_ctr,
   output logic                eng_cbc,
   output logic                eng_encrypt,
   output logic [1:0]          eng_ctr_width,
   output logic [2*DATA_W-1:0] eng_len,
   output logic                cfg_err
);

   localparam int unsigned LEN_W = 2 * DATA_W;

   generate
      if (DATA_W < CTRL_MSB + 1) begin : g_bad_width
         $error("cmc_ctrl: DATA_W too narrow for control word");
      end
      if (CTRL_OFS == LEN_LO_OFS || CTRL_OFS == LEN_HI_OFS ||
          LEN_LO_OFS == LEN_HI_OFS) begin : g_bad_map
         $error("cmc_ctrl: register offsets overlap");
      end
   endgenerate

   mode_cfg_t            cfg_q;
   mode_cfg_t            cfg_new;
   logic [DATA_W-1:0]    len_lo_q;
   logic [DATA_W-1:0]    len_hi_q;
   logic                 wr_ctrl;
   logic                 wr_lo;
   logic                 wr_hi;
   logic                 cfg_change;
   logic                 illegal;
   logic                 ctx_ok;
   logic                 active;
   logic [NUM_FLAGS-1:0] flag_q;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_dma;

   assign wr_ctrl    = bus_wr && (bus_addr == CTRL_OFS);
   assign wr_lo      = bus_wr && (bus_addr == LEN_LO_OFS);
   assign wr_hi      = bus_wr && (bus_addr == LEN_HI_OFS);
   assign cfg_new    = cfg_from_word(bus_wdata[CTRL_MSB:0]);
   assign cfg_change = wr_ctrl && (cfg_new != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         len_lo_q <= '0;
         len_hi_q <= '0;
      end else begin
         if (wr_ctrl) cfg_q    <= cfg_new;
         if (wr_lo)   len_lo_q <= bus_wdata;
         if (wr_hi)   len_hi_q <= bus_wdata;
      end
   end

   cmc_legal #(
      .MAC_ENC_ONLY (MAC_ENC_ONLY)
   ) u_legal (
      .cfg     (cfg_q),
      .illegal (illegal)
   );

   cmc_ctx u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_change (cfg_change),
      .wr_lo      (wr_lo),
      .wr_hi      (wr_hi),
      .illegal    (illegal),
      .ctx_ok     (ctx_ok),
      .start      (eng_start),
      .active     (active),
      .err        (cfg_err)
   );

   // flag 0: output-ready, flag 1: input-ready
   assign flag_set[BIT_ORDY] = eng_out_valid;
   assign flag_set[BIT_IRDY] = ctx_ok | (eng_block_done & active);
   assign flag_dma[BIT_ORDY] = dma_out_take;
   assign flag_dma[BIT_IRDY] = dma_in_take;

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         cmc_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .host_wr  (wr_ctrl),
            .host_bit (bus_wdata[i]),
            .dma_sel  (dma_sel),
            .dma_clr  (flag_dma[i]),
            .set_evt  (flag_set[i]),
            .q        (flag_q[i])
         );
      end
   endgenerate

   logic [CTRL_MSB:0] ctrl_word;

   always_comb begin
      ctrl_word = cfg_to_word(cfg_q);
      ctrl_word[BIT_KEY+1:BIT_KEY] = KEY_128;
      ctrl_word[BIT_IRDY] = flag_q[BIT_IRDY];
      ctrl_word[BIT_ORDY] = flag_q[BIT_ORDY];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == CTRL_OFS) begin
         bus_rdata[CTRL_MSB:0] = ctrl_word;
      end else if (bus_addr == LEN_LO_OFS) begin
         bus_rdata = len_lo_q;
      end else if (bus_addr == LEN_HI_OFS) begin
         bus_rdata = len_hi_q;
      end
   end

   assign eng_in_valid  = active & ~flag_q[BIT_IRDY];
   assign eng_out_free  = ~flag_q[BIT_ORDY];
   assign eng_ccm       = cfg_q.ccm;
   assign eng_mac       = cfg_q.mac;
   assign eng_ctr       = cfg_q.ctr;
   assign eng_cbc       = cfg_q.cbc;
   assign eng_encrypt   = cfg_q.enc;
   assign eng_ctr_width = cfg_q.cw;
   assign eng_len       = {len_hi_q, len_lo_q};

   // R5
   start_sets_irdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (bus_rdata[BIT_IRDY] || bus_addr != CTRL_OFS || $past(flag_q[BIT_IRDY])));

   // R11
   in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !eng_in_valid);

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CTRL_OFS) |-> (bus_rdata[BIT_KEY+1:BIT_KEY] == KEY_128));

   // R3
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(cfg_q));

   initial begin
      assert (LEN_W == 2 * DATA_W);
   end

endmodule

// File: tb/cmc_ctrl_test.sv
module cmc_ctrl_test;

   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          dma_sel = 1'b0;
   logic          dma_in_take = 1'b0;
   logic          dma_out_take = 1'b0;
   logic          eng_block_done = 1'b0;
   logic          eng_out_valid = 1'b0;
   logic          eng_start, eng_in_valid, eng_out_free;
   logic          eng_ccm, eng_mac, eng_ctr, eng_cbc, eng_encrypt;
   logic [1:0]    eng_ctr_width;
   logic [2*DW-1:0] eng_len;
   logic          cfg_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [6:0]    mode;
      logic [63:0]   len;
   } start_item_t;

   start_item_t sb_q[$];

   always #4 clk = ~clk;

   cmc_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_sel(dma_sel),
      .dma_in_take(dma_in_take), .dma_out_take(dma_out_take),
      .eng_block_done(eng_block_done), .eng_out_valid(eng_out_valid),
      .eng_start(eng_start), .eng_in_valid(eng_in_valid),
      .eng_out_free(eng_out_free), .eng_ccm(eng_ccm), .eng_mac(eng_mac),
      .eng_ctr(eng_ctr), .eng_cbc(eng_cbc), .eng_encrypt(eng_encrypt),
      .eng_ctr_width(eng_ctr_width), .eng_len(eng_len), .cfg_err(cfg_err)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] mode_of(input logic [31:0] w);
      return {w[18], w[15], w[6], w[5], w[2], w[8:7]};
   endfunction

   // monitor: every start pulse must match the oldest expected item
   always @(negedge clk) begin
      if (rst_n && eng_start) begin
         if (sb_q.size() == 0) begin
            chk("R5 unexpected start", 64'd1, 64'd0);
         end else begin
            start_item_t it;
            it = sb_q.pop_front();
            chk("R3 start mode", {57'd0, eng_ccm, eng_mac, eng_ctr, eng_cbc,
                eng_encrypt, eng_ctr_width}, {57'd0, it.mode});
            chk("R3 start length", eng_len, it.len);
         end
      end
   end

   task automatic expect_start(input logic [31:0] ctrl, input logic [63:0] len);
      start_item_t it;
      it.mode = mode_of(ctrl);
      it.len  = len;
      sb_q.push_back(it);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic chk_ctrl(input string req, input logic [31:0] exp);
      logic [31:0] v;
      rd(4'h0, v);
      chk(req, {32'd0, v}, {32'd0, exp});
   endtask

   task automatic chk_drained(input string req);
      chk(req, 64'(sb_q.size()), 64'd0);
   endtask

   task automatic pulse_done();
      @(negedge clk); eng_block_done = 1'b1;
      @(negedge clk); eng_block_done = 1'b0; #1;
   endtask

   task automatic pulse_out();
      @(negedge clk); eng_out_valid = 1'b1;
      @(negedge clk); eng_out_valid = 1'b0; #1;
   endtask

   task automatic pulse_din();
      @(negedge clk); dma_in_take = 1'b1;
      @(negedge clk); dma_in_take = 1'b0; #1;
   endtask

   task automatic pulse_dout();
      @(negedge clk); dma_out_take = 1'b1;
      @(negedge clk); dma_out_take = 1'b0; #1;
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk_ctrl("R1 ctrl reset", 32'h0000_0008);
      rd(4'h4, v); chk("R1 len lo reset", {32'd0, v}, 64'd0);
      rd(4'h8, v); chk("R1 len hi reset", {32'd0, v}, 64'd0);
      chk("R1 start", {63'd0, eng_start}, 64'd0);
      chk("R1 err", {63'd0, cfg_err}, 64'd0);
      chk("R1 in_valid", {63'd0, eng_in_valid}, 64'd0);
      chk("R1 out_free", {63'd0, eng_out_free}, 64'd1);

      // R2 reserved bits, read-only key field, written 1s on flags ignored
      wr(4'h0, 32'hFFFF_FFFF);
      chk_ctrl("R2 all-ones write", 32'h0004_81EC);
      wr(4'h0, 32'h0);
      chk_ctrl("R2 cleared", 32'h0000_0008);

      // R3/R4/R5 CTR, 96-bit counter, encrypt
      wr(4'h0, 32'h144);
      chk("R3 width code", {62'd0, eng_ctr_width}, 64'd2);
      chk("R3 encrypt", {63'd0, eng_encrypt}, 64'd1);
      wr(4'h4, 32'h20);
      chk_ctrl("R4 one length word", 32'h14C);
      expect_start(32'h144, 64'h0000_0000_0000_0020);
      wr(4'h8, 32'h0);
      chk_drained("R5 start after both lengths");
      chk_ctrl("R5 input-ready set", 32'h14E);
      rd(4'h4, v); chk("R4 len lo readback", {32'd0, v}, 64'h20);

      // R7 input-ready handshake
      wr(4'h0, 32'h146);
      chk_ctrl("R7 write 1 ignored", 32'h14E);
      chk("R11 in_valid idle", {63'd0, eng_in_valid}, 64'd0);
      wr(4'h0, 32'h144);
      chk_ctrl("R7 write 0 clears", 32'h14C);
      chk("R11 in_valid loaded", {63'd0, eng_in_valid}, 64'd1);
      pulse_done();
      chk_ctrl("R9 block done sets", 32'h14E);
      chk("R11 in_valid after done", {63'd0, eng_in_valid}, 64'd0);

      // R9 set wins over same-cycle clear
      @(negedge clk);
      bus_addr = 4'h0; bus_wdata = 32'h144; bus_wr = 1'b1; eng_block_done = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; eng_block_done = 1'b0; #1;
      chk_ctrl("R9 set beats clear", 32'h14E);

      // R8 output-ready handshake
      pulse_out();
      chk_ctrl("R8 out_valid sets", 32'h14F);
      chk("R8 out_free low", {63'd0, eng_out_free}, 64'd0);
      wr(4'h0, 32'h147);
      chk_ctrl("R8 write 1 ignored", 32'h14F);
      wr(4'h0, 32'h146);
      chk_ctrl("R8 write 0 clears", 32'h14E);
      chk("R8 out_free high", {63'd0, eng_out_free}, 64'd1);

      // R4 config change discards an earlier length write
      wr(4'h4, 32'h40);
      wr(4'h0, 32'h1C6);
      chk("R11 active dropped", {63'd0, eng_in_valid}, 64'd0);
      wr(4'h8, 32'h1);
      chk_drained("R4 stale lower word");
      expect_start(32'h1C4, 64'h0000_0001_0000_0080);
      wr(4'h4, 32'h80);
      chk_drained("R4 upper then lower");
      chk("R3 width 128", {62'd0, eng_ctr_width}, 64'd3);

      // R4 flag-only control write keeps a pending length write
      wr(4'h4, 32'h10);
      wr(4'h0, 32'h1C6);
      expect_start(32'h1C4, 64'h0000_0002_0000_0010);
      wr(4'h8, 32'h2);
      chk_drained("R4 flag write keeps length");

      // R6 illegal combinations
      wr(4'h0, 32'h4_0006);
      wr(4'h4, 32'h5); wr(4'h8, 32'h0);
      chk_drained("R6 ccm without ctr");
      chk("R6 err set", {63'd0, cfg_err}, 64'd1);
      chk("R6 in_valid inactive", {63'd0, eng_in_valid}, 64'd0);
      wr(4'h0, 32'h8002);
      wr(4'h4, 32'h5); wr(4'h8, 32'h0);
      chk_drained("R6 mac with decrypt");
      wr(4'h0, 32'h4_0066);
      wr(4'h4, 32'h5); wr(4'h8, 32'h0);
      chk_drained("R6 ccm with cbc");
      wr(4'h0, 32'h8006);
      expect_start(32'h8006, 64'h0000_0000_0000_0007);
      wr(4'h8, 32'h0); wr(4'h4, 32'h7);
      chk_drained("R6 mac encrypt legal");
      chk("R6 err sticky", {63'd0, cfg_err}, 64'd1);
      wr(4'h0, 32'h4_0042);
      expect_start(32'h4_0042, 64'h0000_0000_0000_0009);
      wr(4'h4, 32'h9); wr(4'h8, 32'h0);
      chk_drained("R6 ccm ctr decrypt legal");

      // R10 DMA pacing
      dma_sel = 1'b1;
      wr(4'h0, 32'h4_0040);
      chk_ctrl("R10 host write ignored", 32'h4_004A);
      pulse_din();
      chk_ctrl("R10 dma clears input", 32'h4_0048);
      pulse_out();
      wr(4'h0, 32'h4_0040);
      chk_ctrl("R10 host out write ignored", 32'h4_0049);
      pulse_dout();
      chk_ctrl("R10 dma clears output", 32'h4_0048);
      dma_sel = 1'b0;
      pulse_done();
      pulse_out();
      pulse_din();
      pulse_dout();
      chk_ctrl("R10 dma pulses ignored", 32'h4_004B);

      repeat (2) @(negedge clk);
      chk_drained("R5 no missing starts");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule